// File: doc/BRIEF.md
# Idle Channel Auto-Mute Detector

This block sits beside a stereo audio sample path and decides when the incoming program material has gone silent in a way that calls for muting. Once per frame a valid strobe presents one left and one right sample word. A channel word whose bits are all zero or all one is treated as quiet. A frame in which both channels are quiet is an idle frame. A saturating counter tracks how many idle frames have arrived back to back. When the run reaches the threshold, the block raises a single mute flag. The downstream output stage uses this flag to silence the converter.

Any frame that carries real data on either channel drops the mute at once and restarts the count. An active-low enable input gates the whole function. While the enable is high the mute output is held low, and the run count is cleared on every strobe. The sample width and the run threshold are parameters. The defaults are 20-bit words and a run of 8192 frames.

Top module: `amute_detect`

## Requirements
- R1: A channel word is quiet only when all of its bits are 0 or all are 1. A frame is idle only when both channels are quiet, and each channel may sit at either level. A word that differs from all-zeros or all-ones in a single bit (for example 20'h00001 or 20'hFFFFE) makes the frame active.
- R2: With the enable low, `mute` rises in the clock cycle after the strobe edge of the IDLE_FRAMES-th consecutive idle frame (8192 by default). After only IDLE_FRAMES-1 consecutive idle frames, `mute` is still 0.
- R3: An active frame on either channel clears `mute` in the cycle after its strobe edge, and the run count restarts from zero.
- R4: While `enable_n` is 1, `mute` reads 0 in the same cycle, without waiting for a strobe. Strobes seen while `enable_n` is 1 clear the run. After re-enabling, a fresh run of IDLE_FRAMES idle frames is needed.
- R5: The run count saturates at IDLE_FRAMES, so `mute` stays at 1 for any number of further idle frames.
- R6: Synchronous reset clears the run count and the mute state. `mute` reads 0 after reset, and a full run is needed afterwards.
- R7: The mute state changes only on clock edges where `smp_vld` is 1. Sample words presented without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe, one per frame, qualifying both sample words |
| left_smp | input | SAMPLE_W | Left channel sample word |
| right_smp | input | SAMPLE_W | Right channel sample word |
| enable_n | input | 1 | Active-low function enable |
| mute | output | 1 | Mute request, high while the input is judged idle |

## Verification
The hardest situation to reach from the ports is the exact threshold edge. A run of IDLE_FRAMES-1 idle frames must leave the flag low, and the next idle frame must set it. Reaching this edge takes thousands of back-to-back strobes. The stimulus therefore issues one strobe per clock and resumes runs at the default threshold. It breaks a nearly complete run with a single active frame and then rebuilds the run with the two channels parked at opposite levels. A reference counter in the bench, fed only from the requirements, predicts the flag after every strobe. This covers the saturation period, the release caused by a one-bit change, and the loss of the accumulated run when the enable is raised or reset is applied mid-mute.

// File: rtl/amute_pkg.sv
package amute_pkg;

    localparam int unsigned DEF_SAMPLE_W    = 20;
    localparam int unsigned DEF_IDLE_FRAMES = 8192;

    typedef enum logic [1:0] {
        LVL_ZERO   = 2'd0,
        LVL_ONE    = 2'd1,
        LVL_ACTIVE = 2'd2
    } chan_lvl_e;

    function automatic chan_lvl_e lvl_of(input logic all_one, input logic all_zero);
        if (all_zero)     return LVL_ZERO;
        else if (all_one) return LVL_ONE;
        else              return LVL_ACTIVE;
    endfunction

    function automatic logic lvl_quiet(input chan_lvl_e lvl);
        return lvl != LVL_ACTIVE;
    endfunction

endpackage

// File: rtl/amute_classify.sv
module amute_classify
    import amute_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    output logic                frame_idle
);

    localparam int unsigned NCH = 2;

    logic [SAMPLE_W-1:0] words [NCH];
    chan_lvl_e           lvl   [NCH];
    logic [NCH-1:0]      quiet;

    assign words[0] = left_smp;
    assign words[1] = right_smp;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_comb begin
            lvl[c]   = lvl_of(&words[c], ~|words[c]);
            quiet[c] = lvl_quiet(lvl[c]);
        end
    end

    assign frame_idle = &quiet;

endmodule

// File: rtl/amute_run_count.sv
module amute_run_count #(
    parameter int unsigned IDLE_FRAMES = 8192,
    localparam int unsigned CW = $clog2(IDLE_FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          idle_in,
    input  logic          arm,
    output logic [CW-1:0] cnt_q,
    output logic          full_next
);

    localparam logic [CW-1:0] LIMIT = CW'(IDLE_FRAMES);

    logic [CW-1:0] cnt_d;

    always_comb begin
        if (!(idle_in && arm))  cnt_d = '0;
        else if (cnt_q < LIMIT) cnt_d = cnt_q + 1'b1;
        else                    cnt_d = cnt_q;
        full_next = (cnt_d == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (step) cnt_q <= cnt_d;
    end

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && idle_in && arm && cnt_q == LIMIT) |=> (cnt_q == LIMIT));

endmodule

// File: rtl/amute_detect.sv
module amute_detect
    import amute_pkg::*;
#(
    parameter int unsigned SAMPLE_W    = DEF_SAMPLE_W,
    parameter int unsigned IDLE_FRAMES = DEF_IDLE_FRAMES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                enable_n,
    output logic                mute
);

    localparam int unsigned CW = $clog2(IDLE_FRAMES + 1);

    logic          frame_idle;
    logic [CW-1:0] cnt_q;
    logic          full_next;
    logic          mute_q;

    amute_classify #(.SAMPLE_W(SAMPLE_W)) u_class (
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .frame_idle(frame_idle)
    );

    amute_run_count #(.IDLE_FRAMES(IDLE_FRAMES)) u_count (
        .clk      (clk),
        .rst      (rst),
        .step     (smp_vld),
        .idle_in  (frame_idle),
        .arm      (!enable_n),
        .cnt_q    (cnt_q),
        .full_next(full_next)
    );

    always_ff @(posedge clk) begin
        if (rst)          mute_q <= 1'b0;
        else if (smp_vld) mute_q <= full_next;
    end

    assign mute = mute_q & ~enable_n;

    // R7
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> $stable(mute_q));

    // R3
    active_release_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !frame_idle) |=> !mute_q);

    // R4
    disabled_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && enable_n) |=> (!mute_q && cnt_q == '0));

    // R2
    rise_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mute_q) |-> ($past(cnt_q) >= CW'(IDLE_FRAMES - 1)));

endmodule

// File: tb/amute_detect_test.sv
module amute_detect_test;

    localparam int W   = 20;
    localparam int THR = 8192;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_vld = 1'b0;
    logic [W-1:0] left_smp = '0;
    logic [W-1:0] right_smp = '0;
    logic         enable_n = 1'b0;
    logic         mute;

    int    n_cmp = 0;
    int    n_bad = 0;
    item_t sb_q[$];

    int    m_cnt = 0;
    logic  m_mute = 1'b0;

    always #2 clk = ~clk;

    amute_detect #(.SAMPLE_W(W), .IDLE_FRAMES(THR)) uut (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .left_smp(left_smp), .right_smp(right_smp),
        .enable_n(enable_n), .mute(mute)
    );

    function automatic logic quiet(input logic [W-1:0] x);
        return (&x) || (~|x);
    endfunction

    task automatic check_now(input logic exp, input string tag);
        n_cmp++;
        if (mute !== exp) begin
            n_bad++;
            $display("FAIL %s: mute=%b expected=%b at %0t", tag, mute, exp, $time);
        end
    endtask

    task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r, input string tag);
        @(negedge clk);
        left_smp  = l;
        right_smp = r;
        smp_vld   = 1'b1;
        if (!enable_n && quiet(l) && quiet(r)) begin
            if (m_cnt < THR) m_cnt++;
        end else begin
            m_cnt = 0;
        end
        m_mute = (m_cnt == THR);
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
        sb_q.push_back('{exp: m_mute && !enable_n, tag: tag});
    endtask

    task automatic run(input int n, input logic [W-1:0] l, input logic [W-1:0] r,
                       input string tag);
        for (int i = 0; i < n; i++) frame(l, r, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_vld = 1'b0;
        m_cnt = 0;
        m_mute = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (mute !== it.exp) begin
                n_bad++;
                $display("FAIL %s: mute=%b expected=%b at %0t", it.tag, mute, it.exp, $time);
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check_now(1'b0, "R6 reset state");

        // R2: one short of threshold stays unmuted
        run(THR - 1, '0, '0, "R2 below threshold");
        @(negedge clk);
        check_now(1'b0, "R2 after THR-1 idle");
        // R3 / R1: one-bit word breaks the run
        frame(20'h00001, '0, "R1 single bit active");
        // R1: channels parked at opposite levels still idle
        run(THR - 1, '1, '0, "R2 mixed levels below");
        frame('1, '0, "R2 threshold frame");
        @(negedge clk);
        check_now(1'b1, "R2 muted at threshold");

        // R5: saturation keeps mute
        run(1500, '0, '1, "R5 saturated");

        // R7: data without strobe ignored
        @(negedge clk);
        left_smp = 20'h12345;
        right_smp = 20'h54321;
        repeat (5) @(negedge clk);
        check_now(1'b1, "R7 no strobe keeps mute");

        // R3: right channel activity releases immediately
        frame('0, 20'h00010, "R3 right active release");
        @(negedge clk);
        check_now(1'b0, "R3 released");

        // R1: rebuild with all ones, break with 20'hFFFFE on left
        run(THR, '1, '1, "R1 all ones run");
        frame(20'hFFFFE, '1, "R1 FFFFE active");
        @(negedge clk);
        check_now(1'b0, "R1 FFFFE released");

        // R4: enable high forces mute low at once
        run(THR, '0, '0, "R4 build mute");
        @(negedge clk);
        check_now(1'b1, "R4 muted before disable");
        enable_n = 1'b1;
        #1;
        check_now(1'b0, "R4 immediate low on disable");
        run(50, '0, '0, "R4 strobes while disabled");
        @(negedge clk);
        enable_n = 1'b0;
        #1;
        check_now(1'b0, "R4 no memory after re-enable");
        run(THR - 1, '0, '0, "R4 fresh run below");
        frame('0, '0, "R4 fresh run threshold");
        @(negedge clk);
        check_now(1'b1, "R4 muted after fresh run");

        // R6: reset mid-mute
        do_reset();
        #1;
        check_now(1'b0, "R6 cleared by reset");
        frame('0, '0, "R6 count restarted");
        run(THR - 2, '0, '0, "R6 below after reset");
        frame('0, '0, "R6 threshold after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule